// File: doc/BRIEF.md
# Graded Alarm Qualification Pipeline

This block turns raw fault bits from several timing monitors into graded, timestamped event records and one-cycle action strobes. Each channel is set up as either a hard alarm (loss of lock, missing pulse) or a secondary alarm. It also has a severity and three programmable cycle counts: debounce, confirm and clear. A secondary fault moves through detection, debounce and confirmation before it is reported. A hard fault is reported on its first sampled cycle. An alarm that has been reported stays active until its raw bit has been low for the clear count. This hysteresis stops a flapping input from producing repeated events.

While a power-sequencing window is open, secondary channels are held off. Hard channels are never held off. Secondary events also pass a rate limiter that admits at most a programmable number of events per programmable window. An event over that cap is discarded and counted. One event leaves per cycle. Hard alarms win arbitration first, and among equals the lowest channel index wins. The block keeps a reported-event counter per channel and one counter for discarded events.

Top module: `alm_pipeline`

## Requirements
- R1: A secondary channel reports an event only after its raw bit is sampled high on 1 + DEB + CFM consecutive clock edges (detection, then debounce, then confirm). The event record is valid on the edge after the last of those samples. A shorter high run produces no event.
- R2: A hard channel reports on the edge after its first high sample. It has no debounce or confirm delay, and the power window does not affect it.
- R3: While `pwr_seq` is high, a secondary channel that is detecting, debouncing or confirming returns to idle and cannot start. No secondary event results from a fault held only inside the window.
- R4: `alarm_act` for a channel stays high after its event until the raw bit is sampled low on 1 + CLR consecutive edges. A raw bit that returns high before then keeps the alarm active and produces no new event.
- R5: Each reported event pulses exactly one action strobe for one cycle. The strobe follows the channel's 2-bit severity: 00 gives `act_warn`, 01 gives `act_degrade`, and 10 or 11 give `act_failover`. One activation yields one strobe, however long the fault is held.
- R6: At most one event is reported per cycle. When several channels are pending, hard channels go first and then the lowest index. Pending channels wait and are not lost.
- R7: Within each window of `rate_win` cycles (counted from reset), at most `rate_cap` secondary events are reported. A further secondary event produces no record and no strobe, and adds 1 to `drop_cnt`. Hard events are exempt.
- R8: The event record carries the channel index, severity, class bit, a free-running cycle timestamp that rises from one event to the next, and the channel's thresholds as {DEB, CFM}.
- R9: `evt_cnt` slice i adds 1 for each event reported on channel i.
- R10: After reset, no event is valid, no alarm is active, no strobe is high, and all counters read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| raw_flt | input | NCH | Raw fault bit per channel |
| is_hard | input | NCH | 1 marks a hard channel |
| sev_cfg | input | 2*NCH | Severity per channel |
| deb_len | input | LW*NCH | Debounce count per channel |
| cfm_len | input | LW*NCH | Confirm count per channel |
| clr_len | input | LW*NCH | Clear count per channel |
| pwr_seq | input | 1 | Power-sequencing window open |
| rate_cap | input | RW | Secondary events admitted per window |
| rate_win | input | IW | Window length in cycles |
| alarm_act | output | NCH | Alarm active per channel |
| evt_vld | output | 1 | Event record valid |
| evt_ch | output | CHW | Event channel index |
| evt_sev | output | 2 | Event severity |
| evt_hard | output | 1 | Event class |
| evt_ts | output | TSW | Event timestamp |
| evt_thr | output | 2*LW | Thresholds {DEB, CFM} |
| act_warn | output | 1 | Warning action strobe |
| act_degrade | output | 1 | Degrade action strobe |
| act_failover | output | 1 | Failover action strobe |
| evt_cnt | output | CNTW*NCH | Reported events per channel |
| drop_cnt | output | CNTW | Rate-limited discards |

## Verification
Two things can happen in the same cycle: a hard channel's first sample and a secondary channel's final confirm sample. The bench causes this by starting a hard fault exactly DEB + CFM cycles after a secondary fault, so both channels become pending on the same edge. The scoreboard then expects the hard record first and the secondary record on the next cycle. It also makes two secondary channels confirm on the same edge, and there it expects the lower index first. It also checks that a grant blocked by the rate cap gives a discard count and no record.

// File: rtl/alm_pkg.sv
package alm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_DEB  = 3'd1,
    ST_CONF = 3'd2,
    ST_ACT  = 3'd3,
    ST_CLR  = 3'd4
  } alm_st_e;

  // one-hot action {failover, degrade, warn}
  function automatic logic [2:0] sev_to_act(input logic [1:0] sev);
    logic [2:0] a;
    case (sev)
      2'b00:   a = 3'b001;
      2'b01:   a = 3'b010;
      default: a = 3'b100;
    endcase
    return a;
  endfunction
endpackage

// File: rtl/alm_chan.sv
module alm_chan import alm_pkg::*; #(
  parameter int LW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          raw,
  input  logic          hard,
  input  logic          pwr_seq,
  input  logic [LW-1:0] deb,
  input  logic [LW-1:0] cfm,
  input  logic [LW-1:0] clr,
  input  logic          grant,
  output logic          pend,
  output logic          active
);
  alm_st_e       st, st_n;
  logic [LW-1:0] cnt, cnt_n;
  logic          fire;
  logic          supp;

  assign supp = pwr_seq & ~hard;

  always_comb begin
    st_n  = st;
    cnt_n = cnt;
    fire  = 1'b0;
    case (st)
      ST_IDLE: begin
        if (raw && hard) begin
          fire = 1'b1;
          st_n = ST_ACT;
        end else if (raw && !supp) begin
          st_n  = ST_DEB;
          cnt_n = LW'(1);
        end
      end
      ST_DEB: begin
        if (supp || !raw) begin
          st_n  = ST_IDLE;
          cnt_n = '0;
        end else if (cnt >= deb) begin
          st_n  = ST_CONF;
          cnt_n = LW'(1);
        end else begin
          cnt_n = cnt + LW'(1);
        end
      end
      ST_CONF: begin
        if (supp || !raw) begin
          st_n  = ST_IDLE;
          cnt_n = '0;
        end else if (cnt >= cfm) begin
          fire  = 1'b1;
          st_n  = ST_ACT;
          cnt_n = '0;
        end else begin
          cnt_n = cnt + LW'(1);
        end
      end
      ST_ACT: begin
        if (!raw) begin
          st_n  = ST_CLR;
          cnt_n = LW'(1);
        end
      end
      ST_CLR: begin
        if (raw) begin
          st_n  = ST_ACT;
          cnt_n = '0;
        end else if (cnt >= clr) begin
          st_n  = ST_IDLE;
          cnt_n = '0;
        end else begin
          cnt_n = cnt + LW'(1);
        end
      end
      default: begin
        st_n  = ST_IDLE;
        cnt_n = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= ST_IDLE;
      cnt  <= '0;
      pend <= 1'b0;
    end else begin
      st   <= st_n;
      cnt  <= cnt_n;
      pend <= (pend & ~grant) | fire;
    end
  end

  assign active = (st == ST_ACT) || (st == ST_CLR);

  // R2: hard fault becomes pending on the very next edge
  a_r2_hard_immediate: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE && raw && hard) |=> pend);
  // R3: power window keeps secondary channel out of the qualify stages
  a_r3_window_hold: assert property (@(posedge clk) disable iff (rst)
    (pwr_seq && !hard) |=> (st != ST_DEB && st != ST_CONF));
  // R4: fault returning during clear goes back to active
  a_r4_hysteresis: assert property (@(posedge clk) disable iff (rst)
    (st == ST_CLR && raw) |=> (st == ST_ACT));
  // R6: an ungranted pending event is kept
  a_r6_pend_kept: assert property (@(posedge clk) disable iff (rst)
    (pend && !grant) |=> pend);
endmodule

// File: rtl/alm_arb.sv
module alm_arb #(
  parameter int NCH = 4,
  parameter int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic [NCH-1:0] pend,
  input  logic [NCH-1:0] hard,
  output logic           gnt_vld,
  output logic [CHW-1:0] gnt_idx,
  output logic [NCH-1:0] gnt_oh,
  output logic           gnt_hard
);
  logic hard_any;

  always_comb begin
    hard_any = |(pend & hard);
    gnt_vld  = |pend;
    gnt_idx  = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (pend[i] && (!hard_any || hard[i])) gnt_idx = CHW'(i);
    end
    gnt_oh   = gnt_vld ? (NCH'(1) << gnt_idx) : '0;
    gnt_hard = gnt_vld & hard[gnt_idx];
  end
endmodule

// File: rtl/alm_rate_lim.sv
module alm_rate_lim #(
  parameter int RW = 4,
  parameter int IW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [RW-1:0] cap,
  input  logic [IW-1:0] win,
  input  logic          req,
  output logic          ok
);
  logic [IW-1:0] win_cnt;
  logic [RW-1:0] used;
  logic          wrap;

  assign wrap = (win == '0) || (win_cnt >= win - IW'(1));
  assign ok   = (used < cap);

  always_ff @(posedge clk) begin
    if (rst) begin
      win_cnt <= '0;
      used    <= '0;
    end else if (wrap) begin
      win_cnt <= '0;
      used    <= '0;
    end else begin
      win_cnt <= win_cnt + IW'(1);
      if (req && ok) used <= used + RW'(1);
    end
  end

  // R7: a refused request does not consume budget
  a_r7_refuse_holds: assert property (@(posedge clk) disable iff (rst)
    (req && !ok && !wrap) |=> $stable(used));
endmodule

// File: rtl/alm_pipeline.sv
module alm_pipeline import alm_pkg::*; #(
  parameter int NCH  = 4,
  parameter int LW   = 8,
  parameter int RW   = 4,
  parameter int IW   = 16,
  parameter int TSW  = 32,
  parameter int CNTW = 16,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NCH-1:0]    raw_flt,
  input  logic [NCH-1:0]    is_hard,
  input  logic [2*NCH-1:0]  sev_cfg,
  input  logic [LW*NCH-1:0] deb_len,
  input  logic [LW*NCH-1:0] cfm_len,
  input  logic [LW*NCH-1:0] clr_len,
  input  logic              pwr_seq,
  input  logic [RW-1:0]     rate_cap,
  input  logic [IW-1:0]     rate_win,
  output logic [NCH-1:0]    alarm_act,
  output logic              evt_vld,
  output logic [CHW-1:0]    evt_ch,
  output logic [1:0]        evt_sev,
  output logic              evt_hard,
  output logic [TSW-1:0]    evt_ts,
  output logic [2*LW-1:0]   evt_thr,
  output logic              act_warn,
  output logic              act_degrade,
  output logic              act_failover,
  output logic [CNTW*NCH-1:0] evt_cnt,
  output logic [CNTW-1:0]   drop_cnt
);
  logic [NCH-1:0] pend;
  logic [NCH-1:0] gnt_oh;
  logic [CHW-1:0] gnt_idx;
  logic           gnt_vld, gnt_hard;
  logic           lim_ok, accept, drop;
  logic [TSW-1:0] ts;
  logic [1:0]     g_sev;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    alm_chan #(.LW(LW)) u_chan (
      .clk    (clk),
      .rst    (rst),
      .raw    (raw_flt[g]),
      .hard   (is_hard[g]),
      .pwr_seq(pwr_seq),
      .deb    (deb_len[g*LW +: LW]),
      .cfm    (cfm_len[g*LW +: LW]),
      .clr    (clr_len[g*LW +: LW]),
      .grant  (gnt_oh[g]),
      .pend   (pend[g]),
      .active (alarm_act[g])
    );

    always_ff @(posedge clk) begin
      if (rst) evt_cnt[g*CNTW +: CNTW] <= '0;
      else if (accept && gnt_idx == CHW'(g))
        evt_cnt[g*CNTW +: CNTW] <= evt_cnt[g*CNTW +: CNTW] + CNTW'(1);
    end
  end

  alm_arb #(.NCH(NCH), .CHW(CHW)) u_arb (
    .pend    (pend),
    .hard    (is_hard),
    .gnt_vld (gnt_vld),
    .gnt_idx (gnt_idx),
    .gnt_oh  (gnt_oh),
    .gnt_hard(gnt_hard)
  );

  alm_rate_lim #(.RW(RW), .IW(IW)) u_lim (
    .clk(clk),
    .rst(rst),
    .cap(rate_cap),
    .win(rate_win),
    .req(gnt_vld & ~gnt_hard),
    .ok (lim_ok)
  );

  assign accept = gnt_vld & (gnt_hard | lim_ok);
  assign drop   = gnt_vld & ~gnt_hard & ~lim_ok;
  assign g_sev  = sev_cfg[gnt_idx*2 +: 2];

  always_ff @(posedge clk) begin
    if (rst) begin
      ts           <= '0;
      evt_vld      <= 1'b0;
      evt_ch       <= '0;
      evt_sev      <= '0;
      evt_hard     <= 1'b0;
      evt_ts       <= '0;
      evt_thr      <= '0;
      act_warn     <= 1'b0;
      act_degrade  <= 1'b0;
      act_failover <= 1'b0;
      drop_cnt     <= '0;
    end else begin
      ts      <= ts + TSW'(1);
      evt_vld <= accept;
      if (accept) begin
        evt_ch   <= gnt_idx;
        evt_sev  <= g_sev;
        evt_hard <= gnt_hard;
        evt_ts   <= ts;
        evt_thr  <= {deb_len[gnt_idx*LW +: LW], cfm_len[gnt_idx*LW +: LW]};
      end
      {act_failover, act_degrade, act_warn} <= accept ? sev_to_act(g_sev) : 3'b000;
      if (drop) drop_cnt <= drop_cnt + CNTW'(1);
    end
  end

  // R5: a strobe only comes with a record, and never two strobes at once
  a_r5_strobe_with_evt: assert property (@(posedge clk) disable iff (rst)
    (act_warn | act_degrade | act_failover) |-> evt_vld);
  a_r5_single_strobe: assert property (@(posedge clk) disable iff (rst)
    $onehot0({act_warn, act_degrade, act_failover}));
  // R6: secondary grant only when no hard channel waits
  a_r6_hard_first: assert property (@(posedge clk) disable iff (rst)
    (gnt_vld && !gnt_hard) |-> !(|(pend & is_hard)));
  // R7: a discarded grant yields no record
  a_r7_drop_silent: assert property (@(posedge clk) disable iff (rst)
    drop |=> !evt_vld);
endmodule

// File: tb/alm_pipeline_tb.sv
module alm_pipeline_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4, LW = 8, RW = 4, IW = 16, TSW = 32, CNTW = 16;
  localparam int CHW = 2;
  localparam int DEB [4] = '{3, 2, 5, 4};
  localparam int CFM [4] = '{2, 4, 5, 4};
  localparam int CLR [4] = '{2, 3, 2, 2};
  localparam logic [1:0] SEV [4] = '{2'b00, 2'b01, 2'b10, 2'b11};
  localparam logic HARD [4] = '{1'b0, 1'b0, 1'b1, 1'b1};

  typedef struct packed {
    logic [CHW-1:0] ch;
    logic [1:0]     sev;
    logic           hard;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NCH-1:0] raw_flt = '0;
  logic pwr_seq = 1'b0;
  logic [RW-1:0] rate_cap = 4'd15;
  logic [IW-1:0] rate_win = 16'd60000;
  logic [NCH-1:0] is_hard;
  logic [2*NCH-1:0] sev_cfg;
  logic [LW*NCH-1:0] deb_len, cfm_len, clr_len;
  logic [NCH-1:0] alarm_act;
  logic evt_vld, evt_hard, act_warn, act_degrade, act_failover;
  logic [CHW-1:0] evt_ch;
  logic [1:0] evt_sev;
  logic [TSW-1:0] evt_ts;
  logic [2*LW-1:0] evt_thr;
  logic [CNTW*NCH-1:0] evt_cnt;
  logic [CNTW-1:0] drop_cnt;

  int n_cmp = 0, n_bad = 0;
  int exp_cnt [4] = '{0, 0, 0, 0};
  exp_t q[$];
  logic [TSW-1:0] prev_ts = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      is_hard[i]            = HARD[i];
      sev_cfg[2*i +: 2]     = SEV[i];
      deb_len[LW*i +: LW]   = LW'(DEB[i]);
      cfm_len[LW*i +: LW]   = LW'(CFM[i]);
      clr_len[LW*i +: LW]   = LW'(CLR[i]);
    end
  end

  alm_pipeline #(.NCH(NCH), .LW(LW), .RW(RW), .IW(IW), .TSW(TSW), .CNTW(CNTW)) u_dut (
    .clk(clk), .rst(rst), .raw_flt(raw_flt), .is_hard(is_hard), .sev_cfg(sev_cfg),
    .deb_len(deb_len), .cfm_len(cfm_len), .clr_len(clr_len), .pwr_seq(pwr_seq),
    .rate_cap(rate_cap), .rate_win(rate_win), .alarm_act(alarm_act),
    .evt_vld(evt_vld), .evt_ch(evt_ch), .evt_sev(evt_sev), .evt_hard(evt_hard),
    .evt_ts(evt_ts), .evt_thr(evt_thr), .act_warn(act_warn), .act_degrade(act_degrade),
    .act_failover(act_failover), .evt_cnt(evt_cnt), .drop_cnt(drop_cnt)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push(input int ch);
    exp_t e;
    e.ch = CHW'(ch); e.sev = SEV[ch]; e.hard = HARD[ch];
    q.push_back(e);
    exp_cnt[ch]++;
  endtask

  // hold a fault long enough to be reported, then let it clear
  task automatic activate(input int ch, input bit reported);
    if (reported) push(ch);
    raw_flt[ch] = 1'b1;
    cyc(HARD[ch] ? 12 : DEB[ch] + CFM[ch] + 12);
    raw_flt[ch] = 1'b0;
    cyc(CLR[ch] + 4);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    cyc(3);
    rst = 1'b0;
    for (int i = 0; i < NCH; i++) exp_cnt[i] = 0;
    cyc(1);
  endtask

  task automatic chk_counts(input string tag);
    for (int i = 0; i < NCH; i++)
      chk(evt_cnt[i*CNTW +: CNTW] == CNTW'(exp_cnt[i]), "R9", tag,
          evt_cnt[i*CNTW +: CNTW], exp_cnt[i]);
  endtask

  // raise a fault and count negedges until the record shows up
  task automatic latency(input int ch, input int exp_lat, input string req);
    int k;
    push(ch);
    raw_flt[ch] = 1'b1;
    k = 0;
    for (int i = 1; i <= 40; i++) begin
      @(negedge clk);
      if (evt_vld && k == 0) k = i;
    end
    chk(k == exp_lat, req, "report latency", k, exp_lat);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst) begin
      prev_ts = '0;
    end else if (evt_vld) begin
      if (q.size() == 0) begin
        chk(1'b0, "R6", "unexpected event on channel", evt_ch, -1);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk(evt_ch == e.ch, "R6", "event channel order", evt_ch, e.ch);
        chk(evt_sev == e.sev && evt_hard == e.hard, "R8", "severity/class",
            {evt_sev, evt_hard}, {e.sev, e.hard});
        chk(evt_thr == {LW'(DEB[e.ch]), LW'(CFM[e.ch])}, "R8", "threshold context",
            evt_thr, {LW'(DEB[e.ch]), LW'(CFM[e.ch])});
        chk({act_failover, act_degrade, act_warn} ==
            {e.sev[1], e.sev == 2'b01, e.sev == 2'b00}, "R5", "action strobe",
            {act_failover, act_degrade, act_warn},
            {e.sev[1], e.sev == 2'b01, e.sev == 2'b00});
      end
      chk(evt_ts > prev_ts, "R8", "timestamp rises", evt_ts, prev_ts + 1);
      prev_ts = evt_ts;
    end else if (act_warn | act_degrade | act_failover) begin
      chk(1'b0, "R5", "strobe without event", {act_failover, act_degrade, act_warn}, 0);
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    do_reset();
    // R10: reset state
    chk(!evt_vld && alarm_act == '0 && drop_cnt == '0, "R10", "reset outputs",
        {evt_vld, alarm_act}, 0);
    chk(!(act_warn | act_degrade | act_failover), "R10", "reset strobes", 1, 0);
    chk_counts("R10 reset counters");

    // R1: one sample short of qualification gives nothing
    raw_flt[0] = 1'b1; cyc(DEB[0] + CFM[0]); raw_flt[0] = 1'b0; cyc(10);
    chk(alarm_act[0] == 1'b0, "R1", "short run not active", alarm_act[0], 0);
    // R1: full run reports at 1+DEB+CFM samples plus one
    latency(0, DEB[0] + CFM[0] + 2, "R1");
    // R5: fault still held: no second strobe (scoreboard sees any extra)
    cyc(20);
    raw_flt[0] = 1'b0;
    cyc(2);
    chk(alarm_act[0] == 1'b1, "R4", "active during clear", alarm_act[0], 1);
    cyc(1);
    chk(alarm_act[0] == 1'b0, "R4", "cleared after 1+CLR low", alarm_act[0], 0);

    // R4: hysteresis on channel 1
    push(1);
    raw_flt[1] = 1'b1; cyc(DEB[1] + CFM[1] + 6);
    raw_flt[1] = 1'b0; cyc(2);
    raw_flt[1] = 1'b1; cyc(5);
    chk(alarm_act[1] == 1'b1, "R4", "flap keeps alarm active", alarm_act[1], 1);
    raw_flt[1] = 1'b0; cyc(CLR[1] + 4);
    chk(alarm_act[1] == 1'b0, "R4", "cleared after flap", alarm_act[1], 0);
    chk_counts("R4 single event for flapping fault");

    // R2 and R3: power window open
    pwr_seq = 1'b1;
    raw_flt[0] = 1'b1;
    latency(2, 2, "R2");
    cyc(20);
    chk(alarm_act[0] == 1'b0, "R3", "secondary held off in window", alarm_act[0], 0);
    raw_flt[0] = 1'b0; raw_flt[2] = 1'b0;
    cyc(2);
    pwr_seq = 1'b0;
    cyc(10);
    chk_counts("R3 counters after window");

    // R6: hard and secondary pending on the same edge
    push(3); push(0);
    exp_cnt[3]--; exp_cnt[0]--;
    q.delete();
    push(3); push(0);
    raw_flt[0] = 1'b1; cyc(DEB[0] + CFM[0]);
    raw_flt[3] = 1'b1; cyc(10);
    chk(alarm_act[0] && alarm_act[3], "R6", "both active", alarm_act, 4'b1001);
    raw_flt[0] = 1'b0; raw_flt[3] = 1'b0; cyc(8);
    // R6: two secondaries confirm together, lower index first
    push(0); push(1);
    raw_flt[1] = 1'b1; cyc(1);
    raw_flt[0] = 1'b1; cyc(14);
    raw_flt[0] = 1'b0; raw_flt[1] = 1'b0; cyc(10);
    chk(q.size() == 0, "R6", "all pending events delivered", q.size(), 0);
    chk_counts("R9 after arbitration");

    // R7: cap of two per long window, hard exempt
    rate_cap = 4'd2; rate_win = 16'd60000;
    do_reset();
    activate(0, 1'b1);
    activate(0, 1'b1);
    activate(0, 1'b0);
    chk(drop_cnt == CNTW'(1), "R7", "drop count", drop_cnt, 1);
    activate(2, 1'b1);
    chk(drop_cnt == CNTW'(1), "R7", "hard not limited", drop_cnt, 1);
    chk_counts("R7 counters");

    // R7: budget returns in a new window
    rate_cap = 4'd1; rate_win = 16'd100;
    do_reset();
    activate(0, 1'b1);
    activate(0, 1'b0);
    chk(drop_cnt == CNTW'(1), "R7", "second in window dropped", drop_cnt, 1);
    cyc(250);
    activate(0, 1'b1);
    chk(drop_cnt == CNTW'(1), "R7", "new window admits", drop_cnt, 1);
    chk_counts("R7 window counters");
    chk(q.size() == 0, "R7", "scoreboard drained", q.size(), 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule